// File: doc/BRIEF.md
# Strided Rectangular Block Copy Engine

This engine moves a rectangle of bytes, one scanline at a time, from a source region to a destination region. Either region may be the local staging buffer or an external memory bank; each is selected by a bank index. For every line the engine asks a downstream memory port for a read burst from the source. Once that burst has completed, it asks for a write burst of the same length to the destination.

After each line, the source address and the destination address can each be moved on by their own stride. Each stride has its own enable, so the same engine covers plain linear copies, packing a screen rectangle into contiguous memory, unpacking it again, and copies where both sides step by different amounts. Every address update wraps inside the bank's address mask, so it never spills into a neighbouring bank.

All progress (current addresses, lines left, which half of the line is in flight) is held in registers. The downstream port can therefore serve other, higher-priority requesters between any two of the engine's bursts, simply by holding the ready signal low.

Top module: `blit2d_engine`

## Requirements
- R1: After reset, busy, done, err and cmd_valid are all low.
- R2: Each line first presents one read command (cmd_write=0) on the source bank, with cmd_len equal to the per-line byte count. After that command's completion (cmd_done), one write command (cmd_write=1) of the same length is presented on the destination bank. cmd_valid stays low from each handshake until the matching cmd_done.
- R3: When a line's write completes, the source address advances by src_step if src_step_en is set and is otherwise unchanged. The destination address follows the same rule with dst_step and dst_step_en, independently of the source. Addresses and strides are byte granular and may be odd.
- R4: The mask of bank b is bank_mask[b*AW +: AW]. Starting addresses are ANDed with their bank's mask. Each advance computes (addr + step) AND mask, so cmd_addr never has a bit set outside its bank's mask.
- R5: After the write of line line_count completes, done is high for exactly one cycle, in the cycle that follows that cmd_done, and busy is low in that cycle.
- R6: A start with line_count equal to zero issues no command and raises done for one cycle, in the cycle after start.
- R7: If bit dst_bank of bank_ro is set, start is rejected. err is high for one cycle in the cycle after start, no command is issued, and done stays low.
- R8: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_write, cmd_bank, cmd_addr and cmd_len hold their values.
- R9: A start while busy is ignored: it raises neither done nor err, and the copy in progress continues with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy with the parameters below |
| src_bank | input | BW | Source bank index |
| src_addr | input | AW | Source start address within the bank |
| dst_bank | input | BW | Destination bank index |
| dst_addr | input | AW | Destination start address within the bank |
| line_bytes | input | LW | Bytes per line |
| line_count | input | CW | Number of lines |
| src_step | input | AW | Source stride added after each line |
| src_step_en | input | 1 | Enable source stride |
| dst_step | input | AW | Destination stride added after each line |
| dst_step_en | input | 1 | Enable destination stride |
| bank_mask | input | NBANK*AW | Address mask for every bank |
| bank_ro | input | NBANK | Read-only flag for every bank |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle pulse when a copy completes |
| err | output | 1 | One-cycle pulse when a start is rejected |
| cmd_valid | output | 1 | Burst command present |
| cmd_ready | input | 1 | Port accepts the command |
| cmd_write | output | 1 | 1 for write burst, 0 for read burst |
| cmd_bank | output | BW | Bank of the burst |
| cmd_addr | output | AW | Start address of the burst |
| cmd_len | output | LW | Burst length in bytes |
| cmd_done | input | 1 | Completion pulse of the accepted burst |

## Verification
The bench sweeps every source and destination bank pairing, both stride enables, and line counts of zero, one and three. It uses odd addresses and strides and masks narrow enough that the strides wrap, so an engine that let carries escape the mask would present out-of-bank addresses. An engine that swapped the stride enables, or that advanced an address whose enable was clear, would present a wrong address on the second or third line. It deliberately holds cmd_ready low and delays cmd_done, so a design that dropped or altered a stalled command, or that wrote before the read finished, shows up at once. It also covers a zero line count, which a design could wrongly run as a full counter wrap; a read-only destination, which a design could copy into; and a second start pulse mid-copy, which a design could wrongly latch and so corrupt the copy in flight.

// File: rtl/blit2d_engine.sv
module blit2d_engine #(
  parameter int AW    = 16,
  parameter int BW    = 2,
  parameter int LW    = 12,
  parameter int CW    = 10,
  parameter int NBANK = 1 << BW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BW-1:0]         src_bank,
  input  logic [AW-1:0]         src_addr,
  input  logic [BW-1:0]         dst_bank,
  input  logic [AW-1:0]         dst_addr,
  input  logic [LW-1:0]         line_bytes,
  input  logic [CW-1:0]         line_count,
  input  logic [AW-1:0]         src_step,
  input  logic                  src_step_en,
  input  logic [AW-1:0]         dst_step,
  input  logic                  dst_step_en,
  input  logic [NBANK*AW-1:0]   bank_mask,
  input  logic [NBANK-1:0]      bank_ro,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic                  cmd_write,
  output logic [BW-1:0]         cmd_bank,
  output logic [AW-1:0]         cmd_addr,
  output logic [LW-1:0]         cmd_len,
  input  logic                  cmd_done
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWAIT, S_WR, S_WWAIT} st_t;

  st_t           st;
  logic [BW-1:0] sb, db;
  logic [AW-1:0] sa, da, sstep, dstep;
  logic          sen, den;
  logic [LW-1:0] len;
  logic [CW-1:0] left;

  wire [AW-1:0] smask    = bank_mask[sb*AW +: AW];
  wire [AW-1:0] dmask    = bank_mask[db*AW +: AW];
  wire [AW-1:0] in_smask = bank_mask[src_bank*AW +: AW];
  wire [AW-1:0] in_dmask = bank_mask[dst_bank*AW +: AW];

  assign busy      = (st != S_IDLE);
  assign cmd_valid = (st == S_RD) || (st == S_WR);
  assign cmd_write = (st == S_WR);
  assign cmd_bank  = cmd_write ? db : sb;
  assign cmd_addr  = cmd_write ? da : sa;
  assign cmd_len   = len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
      sb    <= '0;
      db    <= '0;
      sa    <= '0;
      da    <= '0;
      sstep <= '0;
      dstep <= '0;
      sen   <= 1'b0;
      den   <= 1'b0;
      len   <= '0;
      left  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bank_ro[dst_bank])      err  <= 1'b1;
          else if (line_count == '0)  done <= 1'b1;
          else begin
            sb    <= src_bank;
            db    <= dst_bank;
            sa    <= src_addr & in_smask;
            da    <= dst_addr & in_dmask;
            sstep <= src_step;
            dstep <= dst_step;
            sen   <= src_step_en;
            den   <= dst_step_en;
            len   <= line_bytes;
            left  <= line_count;
            st    <= S_RD;
          end
        end
        S_RD:    if (cmd_ready) st <= S_RWAIT;
        S_RWAIT: if (cmd_done)  st <= S_WR;
        S_WR:    if (cmd_ready) st <= S_WWAIT;
        S_WWAIT: if (cmd_done) begin
          if (sen) sa <= (sa + sstep) & smask;
          if (den) da <= (da + dstep) & dmask;
          left <= left - 1'b1;
          if (left == CW'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blit2d_engine_chk.sv
module blit2d_engine_chk #(
  parameter int AW    = 16,
  parameter int BW    = 2,
  parameter int LW    = 12,
  parameter int NBANK = 1 << BW
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NBANK*AW-1:0] bank_mask,
  input logic [NBANK-1:0]    bank_ro,
  input logic                busy,
  input logic                done,
  input logic                err,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                cmd_write,
  input logic [BW-1:0]       cmd_bank,
  input logic [AW-1:0]       cmd_addr,
  input logic [LW-1:0]       cmd_len,
  input logic                cmd_done
);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_write) && $stable(cmd_bank)
      && $stable(cmd_addr) && $stable(cmd_len));

  p_addr_in_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr & ~bank_mask[cmd_bank*AW +: AW]) == '0);

  p_drop_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  p_write_after_read_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid && cmd_write) |-> $past(cmd_done));

  p_no_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write |-> !bank_ro[cmd_bank]);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_valid && !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_valid);

endmodule

bind blit2d_engine blit2d_engine_chk #(.AW(AW), .BW(BW), .LW(LW), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_mask(bank_mask), .bank_ro(bank_ro),
  .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
  .cmd_done(cmd_done)
);

// File: tb/tb_blit2d_engine.sv
module tb_blit2d_engine;
  localparam int AW = 8, BW = 2, LW = 6, CW = 4, NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BW-1:0] src_bank = '0, dst_bank = '0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0, src_step = '0, dst_step = '0;
  logic [LW-1:0] line_bytes = '0;
  logic [CW-1:0] line_count = '0;
  logic src_step_en = 1'b0, dst_step_en = 1'b0;
  logic [NB*AW-1:0] bank_mask = {8'hFF, 8'h0F, 8'h3F, 8'h7F};
  logic [NB-1:0] bank_ro = 4'b1000;
  logic busy, done, err, cmd_valid, cmd_write;
  logic cmd_ready = 1'b0, cmd_done = 1'b0;
  logic [BW-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  blit2d_engine #(.AW(AW), .BW(BW), .LW(LW), .CW(CW), .NBANK(NB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_bank(src_bank), .src_addr(src_addr),
    .dst_bank(dst_bank), .dst_addr(dst_addr), .line_bytes(line_bytes), .line_count(line_count),
    .src_step(src_step), .src_step_en(src_step_en), .dst_step(dst_step), .dst_step_en(dst_step_en),
    .bank_mask(bank_mask), .bank_ro(bank_ro), .busy(busy), .done(done), .err(err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_done(cmd_done));

  function automatic logic [AW-1:0] msk(input int b);
    return bank_mask[b*AW +: AW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic expect_cmd(input bit w, input int bank, input logic [AW-1:0] addr,
                            input logic [LW-1:0] len, input int hold, input int dly);
    logic [AW-1:0] a0;
    int n = 0;
    while (!cmd_valid && n < 40) begin tick; n++; end
    chk(cmd_valid, "R2 valid", 32'(cmd_valid), 1);
    chk(cmd_write == w, "R2 direction", 32'(cmd_write), 32'(w));
    chk(cmd_bank == BW'(bank), "R2 bank", 32'(cmd_bank), 32'(bank));
    chk(cmd_addr == addr, w ? "R3/R4 dst addr" : "R3/R4 src addr", 32'(cmd_addr), 32'(addr));
    chk(cmd_len == len, "R2 len", 32'(cmd_len), 32'(len));
    a0 = cmd_addr;
    repeat (hold) tick;
    if (hold > 0)
      chk(cmd_valid && cmd_addr == a0 && cmd_write == w, "R8 held", 32'(cmd_addr), 32'(a0));
    cmd_ready = 1'b1;
    tick;
    cmd_ready = 1'b0;
    repeat (dly) begin
      chk(!cmd_valid, "R2 wait for completion", 32'(cmd_valid), 0);
      tick;
    end
    cmd_done = 1'b1;
    tick;
    cmd_done = 1'b0;
  endtask

  task automatic run(input int sb, input int db, input bit se, input bit de, input int lc);
    logic [AW-1:0] sa, da;
    logic [LW-1:0] ln;
    src_bank    = BW'(sb);
    dst_bank    = BW'(db);
    src_addr    = 8'hE5 ^ AW'(sb * 17 + db * 3);
    dst_addr    = 8'h3B + AW'(db * 29 + sb);
    src_step    = 8'h29 + AW'(sb * 2);
    dst_step    = 8'hC3 - AW'(db);
    src_step_en = se;
    dst_step_en = de;
    ln          = LW'(1 + (sb * 4 + db * 7 + lc) % 63);
    line_bytes  = ln;
    line_count  = CW'(lc);
    start = 1'b1;
    tick;
    start = 1'b0;
    if (bank_ro[db]) begin
      chk(err && !done && !cmd_valid, "R7 reject", {29'd0, err, done, cmd_valid}, 32'b100);
      tick;
      chk(!err && !cmd_valid && !busy, "R7 pulse ends", {29'd0, err, cmd_valid, busy}, 0);
      return;
    end
    if (lc == 0) begin
      chk(done && !cmd_valid && !busy, "R6 empty copy", {29'd0, done, cmd_valid, busy}, 32'b100);
      tick;
      chk(!done, "R6 pulse ends", 32'(done), 0);
      return;
    end
    sa = src_addr & msk(sb);
    da = dst_addr & msk(db);
    if (lc == 3) begin
      src_bank = 2'd1; dst_bank = 2'd3; line_count = '0; src_addr = 8'h00;
      start = 1'b1;
      tick;
      start = 1'b0;
      chk(!done && !err && busy, "R9 start ignored", {29'd0, done, err, busy}, 1);
    end
    for (int l = 0; l < lc; l++) begin
      expect_cmd(1'b0, sb, sa, ln, (l + sb) % 3, (l + db) % 4);
      expect_cmd(1'b1, db, da, ln, (l + db + 1) % 3, (l + sb + 1) % 4);
      if (se) sa = (sa + src_step) & msk(sb);
      if (de) da = (da + dst_step) & msk(db);
      if (l == lc - 1)
        chk(done && !busy, "R5 done after last line", {30'd0, done, busy}, 32'b10);
      else
        chk(!done && busy, "R5 no early done", {30'd0, done, busy}, 32'b01);
    end
    tick;
    chk(!done, "R5 done is one cycle", 32'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick;
    chk(!busy && !done && !err && !cmd_valid, "R1 reset state",
        {28'd0, busy, done, err, cmd_valid}, 0);
    rst_n = 1'b1;
    tick;
    for (int sb = 0; sb < NB; sb++)
      for (int db = 0; db < NB; db++)
        for (int se = 0; se < 2; se++)
          for (int de = 0; de < 2; de++)
            for (int li = 0; li < 3; li++) begin
              run(sb, db, se[0], de[0], (li == 0) ? 0 : (li == 1) ? 1 : 3);
              repeat (2) tick;
            end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule